// File: doc/BRIEF.md
# Parallel LCD Output Data Repeater

This block feeds an 8- or 16-bit parallel LCD bus in master transmit mode. It pulls data words from a transmit FIFO through a valid/ready handshake and drives one word onto the bus per bus clock. Each driven word comes with a one-cycle write strobe. Clock division, DMA, register access and the LCD command/data protocol belong to other blocks.

Two control inputs choose how words are repeated. In the plain pattern every word appears once. In the doubled pattern every word appears on two cycles in a row. In the paired pattern words are taken two at a time and the pair is replayed as A, B, A, B. A pattern that is under way always runs to completion before the control inputs are looked at again.

When the FIFO cannot supply a word that is needed, the bus keeps its last value, the strobe stays low and a sticky underflow flag is raised.

Top module: `lcd_rep_top`

## Requirements
- R1: With `rep_word`=0 and `rep_pair`=0, each accepted word is strobed onto the bus on exactly one cycle, in acceptance order.
- R2: With `rep_word`=1 and `rep_pair`=0, each accepted word is strobed on two consecutive bus cycles, in acceptance order.
- R3: With `rep_word`=1 and `rep_pair`=1, words are accepted two at a time and strobed in the order first, second, first, second.
- R4: With `rep_word`=0 and `rep_pair`=1, the output is identical to the R3 pattern.
- R5: While `rst` is high and on the cycle after it falls, `bus_wr`=0, `underflow`=0 and `bus_data`=0. The block then starts in the plain pattern when both control inputs are 0.
- R6: In the paired pattern, no word is strobed from the moment the first word of a pair is accepted until the second word is accepted. The first word of the pair is strobed on the cycle after the second is accepted.
- R7: `bus_wr` is high only in the cycle after a cycle with `en` high. While `en` is low, `in_ready` stays low and the pattern position is frozen, so it resumes where it stopped.
- R8: When a new word is needed with `en` high and `in_valid` low, `bus_data` holds its value, `bus_wr` stays low and `underflow` becomes 1. `underflow` stays 1 until `rst`. Whenever `bus_wr` is low, `bus_data` is unchanged.
- R9: Changes to `rep_word`/`rep_pair` take effect only at the first word of a new pattern. They never alter a repeat or a pair already under way.
- R10: `in_ready` is high only in a cycle where a word is latched, which needs `en` and `in_valid` both high. The plain pattern consumes one word per slot, and the doubled pattern one word per two strobes. The paired pattern consumes two words per four strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Transmit enable |
| rep_word | input | 1 | Word-repeat control |
| rep_pair | input | 1 | Pair-repeat control (implies word repeat) |
| in_valid | input | 1 | FIFO has a word |
| in_data | input | DATA_W | FIFO word |
| in_ready | output | 1 | Word taken this cycle |
| bus_data | output | DATA_W | Parallel LCD data bus |
| bus_wr | output | 1 | Write strobe, one cycle per driven word |
| underflow | output | 1 | Sticky FIFO underflow flag |

## Verification
The bench builds the block with `DATA_W`=8. Random byte data therefore often repeats values, which exercises the hold-on-gap check with equal and unequal neighbours. Random segments in each pattern use gaps in valid and enable, so starvation mid-pair and freezes mid-repeat occur many times. Directed cases then switch the control inputs in the middle of a double or a pair to show the pattern is locked until it ends.

// File: rtl/lcd_rep_pkg.sv
package lcd_rep_pkg;

  typedef enum logic [1:0] {
    RM_ONCE  = 2'd0,
    RM_TWICE = 2'd1,
    RM_PAIR  = 2'd2
  } rep_mode_e;

  typedef enum logic [1:0] {
    SRC_FIFO = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2
  } src_e;

  localparam int PH_W = 2;

  // Pair bit dominates; it alone still gives the paired pattern.
  function automatic rep_mode_e decode_mode(input logic word_bit, input logic pair_bit);
    if (pair_bit)      return RM_PAIR;
    else if (word_bit) return RM_TWICE;
    else               return RM_ONCE;
  endfunction

  // Final phase index of a pattern before wrapping to its start.
  function automatic logic [PH_W-1:0] last_phase(input rep_mode_e m);
    case (m)
      RM_TWICE: return 2'd1;
      RM_PAIR:  return 2'd3;
      default:  return 2'd0;
    endcase
  endfunction

  // Which stored word a replay phase shows.
  function automatic src_e replay_src(input rep_mode_e m, input logic [PH_W-1:0] ph);
    if (ph == 2'd1) return (m == RM_TWICE) ? SRC_A : SRC_B;
    else if (ph == 2'd2) return SRC_A;
    else return SRC_B;
  endfunction

endpackage

// File: rtl/lcd_rep_mode_sel.sv
module lcd_rep_mode_sel
  import lcd_rep_pkg::*;
(
  input  logic      rep_word,
  input  logic      rep_pair,
  output rep_mode_e mode_req
);
  always_comb mode_req = decode_mode(rep_word, rep_pair);
endmodule

// File: rtl/lcd_rep_seq.sv
module lcd_rep_seq
  import lcd_rep_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            in_valid,
  input  rep_mode_e       mode_req,
  output logic            pop,
  output logic            ld_a,
  output logic            ld_b,
  output logic            drive,
  output logic            starve,
  output src_e            sel,
  output logic            pair_armed
);
  logic [PH_W-1:0] ph;
  rep_mode_e       mode_q;
  rep_mode_e       start_mode;
  logic            at_start;
  logic            need;

  always_comb begin
    at_start   = (ph == '0);
    start_mode = pair_armed ? RM_PAIR : mode_req;
    need       = en && at_start;
    starve     = need && !in_valid;
    pop        = need && in_valid;
    ld_a       = pop && !pair_armed && (start_mode != RM_ONCE);
    ld_b       = pop && pair_armed;
    drive      = en && (!at_start || (pop && !(start_mode == RM_PAIR && !pair_armed)));
    if (at_start) sel = pair_armed ? SRC_A : SRC_FIFO;
    else          sel = replay_src(mode_q, ph);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= '0;
      pair_armed <= 1'b0;
      mode_q     <= RM_ONCE;
    end else if (en) begin
      if (at_start) begin
        if (pop) begin
          if (!pair_armed) begin
            mode_q <= start_mode;
            if (start_mode == RM_TWICE)     ph <= 2'd1;
            else if (start_mode == RM_PAIR) pair_armed <= 1'b1;
          end else begin
            pair_armed <= 1'b0;
            ph         <= 2'd1;
          end
        end
      end else begin
        ph <= (ph == last_phase(mode_q)) ? '0 : ph + 2'd1;
      end
    end
  end

  // R10: nothing is taken from the FIFO while a repeat is replaying.
  assert_no_pop_mid_repeat_R10: assert property (@(posedge clk) disable iff (rst)
    (ph != '0) |-> !pop);

  // R9: the latched pattern cannot change while a pattern is under way.
  assert_mode_locked_R9: assert property (@(posedge clk) disable iff (rst)
    ((ph != '0) || pair_armed) |=> $stable(mode_q));

  // R7: a frozen sequencer keeps its position.
  assert_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(ph) && $stable(pair_armed)));
endmodule

// File: rtl/lcd_rep_dp.sv
module lcd_rep_dp
  import lcd_rep_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic              ld_a,
  input  logic              ld_b,
  input  logic              drive,
  input  logic              starve,
  input  src_e              sel,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_wr,
  output logic              underflow
);
  logic [DATA_W-1:0] hold_a;
  logic [DATA_W-1:0] hold_b;
  logic [DATA_W-1:0] next_word;

  always_comb begin
    case (sel)
      SRC_A:   next_word = hold_a;
      SRC_B:   next_word = hold_b;
      default: next_word = in_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_a    <= '0;
      hold_b    <= '0;
      bus_data  <= '0;
      bus_wr    <= 1'b0;
      underflow <= 1'b0;
    end else begin
      if (ld_a) hold_a <= in_data;
      if (ld_b) hold_b <= in_data;
      if (drive) bus_data <= next_word;
      bus_wr    <= drive;
      underflow <= underflow | starve;
    end
  end

  // R8: the bus holds its value on every cycle without a strobe.
  assert_hold_bus_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_wr |-> $stable(bus_data));

  // R8: underflow is sticky until reset.
  assert_uflow_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);
endmodule

// File: rtl/lcd_rep_top.sv
module lcd_rep_top
  import lcd_rep_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              rep_word,
  input  logic              rep_pair,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] bus_data,
  output logic              bus_wr,
  output logic              underflow
);
  rep_mode_e mode_req;
  logic      pop, ld_a, ld_b, drive, starve, pair_armed;
  src_e      sel;

  lcd_rep_mode_sel u_mode (
    .rep_word (rep_word),
    .rep_pair (rep_pair),
    .mode_req (mode_req)
  );

  lcd_rep_seq u_seq (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .in_valid   (in_valid),
    .mode_req   (mode_req),
    .pop        (pop),
    .ld_a       (ld_a),
    .ld_b       (ld_b),
    .drive      (drive),
    .starve     (starve),
    .sel        (sel),
    .pair_armed (pair_armed)
  );

  lcd_rep_dp #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .in_data   (in_data),
    .ld_a      (ld_a),
    .ld_b      (ld_b),
    .drive     (drive),
    .starve    (starve),
    .sel       (sel),
    .bus_data  (bus_data),
    .bus_wr    (bus_wr),
    .underflow (underflow)
  );

  assign in_ready = pop;

  // R10: a word is taken only when offered and enabled.
  assert_ready_qualified_R10: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> (in_valid && en));

  // R7: a strobe follows only an enabled cycle.
  assert_wr_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
    bus_wr |-> $past(en));

  // R6: no strobe while half a pair is held.
  assert_pair_waits_R6: assert property (@(posedge clk) disable iff (rst)
    pair_armed |-> !bus_wr);
endmodule

// File: tb/sim_lcd_rep_top.sv
module sim_lcd_rep_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          en = 1'b0, rep_word = 1'b0, rep_pair = 1'b0, in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, bus_wr, underflow;
  logic [DW-1:0] bus_data;

  int  n_chk = 0, n_fail = 0, cyc = 0;
  bit  done = 0;

  logic [DW-1:0] src [64];
  logic [DW-1:0] got [256];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_rep_top #(.DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .en(en), .rep_word(rep_word), .rep_pair(rep_pair),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .bus_data(bus_data), .bus_wr(bus_wr), .underflow(underflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode: 0 once, 1 twice, 2 paired
  function automatic int exp_len(input int mode, input int n);
    return (mode == 0) ? n : 2 * n;
  endfunction

  function automatic logic [DW-1:0] exp_word(input int mode, input int k);
    if (mode == 0) return src[k];
    if (mode == 1) return src[k / 2];
    return src[2 * (k / 4) + (k % 2)];
  endfunction

  // One bus cycle: drive at negedge, read ready, observe after the edge.
  task automatic tick(input logic e, input logic v, input logic [DW-1:0] d,
                      input logic w, input logic p,
                      output logic rdy, output logic wr, output logic [DW-1:0] bus);
    en = e; in_valid = v; in_data = d; rep_word = w; rep_pair = p;
    #1 rdy = in_ready;
    @(posedge clk);
    @(negedge clk);
    wr = bus_wr; bus = bus_data;
  endtask

  task automatic do_reset();
    rst = 1'b1; en = 0; in_valid = 0; rep_word = 0; rep_pair = 0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic segment(input int mode, input logic w, input logic p, input int n, input string req);
    int idx = 0, ng = 0, guard = 0;
    logic rdy, wr, e, v;
    logic [DW-1:0] bus, prev;
    prev = bus_data;
    for (int i = 0; i < n; i++) src[i] = DW'($urandom);
    while ((idx < n || ng < exp_len(mode, n)) && guard < 3000) begin
      e = ($urandom % 10) < 8;
      v = (idx < n) && (($urandom % 10) < 7);
      tick(e, v, (idx < n) ? src[idx] : '0, w, p, rdy, wr, bus);
      if (rdy) begin
        if (!(e && v)) chk(0, "R10 ready unqualified", 1, 0);
        idx++;
      end
      if (wr && !e) chk(0, "R7 strobe without enable", 1, 0);
      if (!wr && bus != prev) chk(0, "R8 bus moved without strobe", bus, prev);
      if (wr) begin
        if (ng < 256) got[ng] = bus;
        ng++;
      end
      prev = bus;
      guard++;
    end
    chk(ng == exp_len(mode, n), {req, " R10 strobe count"}, ng, exp_len(mode, n));
    for (int k = 0; k < exp_len(mode, n) && k < ng; k++)
      chk(got[k] == exp_word(mode, k), req, got[k], exp_word(mode, k));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic rdy, wr;
    logic [DW-1:0] bus;
    void'($urandom(32'd4321));

    // R5: reset state
    @(negedge clk);
    chk(bus_wr == 0, "R5 wr in reset", bus_wr, 0);
    chk(underflow == 0, "R5 underflow in reset", underflow, 0);
    do_reset();
    chk(bus_wr == 0 && underflow == 0 && bus_data == 0, "R5 outputs after reset",
        {bus_wr, underflow, bus_data}, 0);

    // R7: enable low takes nothing and strobes nothing
    for (int i = 0; i < 4; i++) begin
      tick(0, 1, 8'h5a, 0, 0, rdy, wr, bus);
      chk(rdy == 0, "R7 ready while disabled", rdy, 0);
      chk(wr == 0, "R7 strobe while disabled", wr, 0);
    end
    // R5/R1: default pattern with both controls low
    tick(1, 1, 8'h3c, 0, 0, rdy, wr, bus);
    chk(rdy && wr && bus == 8'h3c, "R5 default plain pattern", bus, 8'h3c);

    // Random segments in each pattern
    segment(0, 0, 0, 40, "R1 plain");
    segment(1, 1, 0, 30, "R2 doubled");
    segment(2, 1, 1, 30, "R3 paired");
    segment(2, 0, 1, 30, "R4 pair bit alone");
    segment(0, 0, 0, 20, "R1 plain again");

    // R6/R8/R9: half a pair held, starved, then control changed
    do_reset();
    tick(1, 1, 8'ha1, 0, 1, rdy, wr, bus);
    chk(rdy == 1 && wr == 0, "R6 first of pair no strobe", {rdy, wr}, 2'b10);
    for (int i = 0; i < 2; i++) begin
      tick(1, 0, 8'h00, 0, 1, rdy, wr, bus);
      chk(wr == 0 && bus == 8'h00, "R8 starved pair holds bus", {wr, bus}, 0);
    end
    chk(underflow == 1, "R8 underflow raised", underflow, 1);
    tick(1, 1, 8'hb2, 0, 0, rdy, wr, bus);
    chk(rdy && wr && bus == 8'ha1, "R6 pair starts after second", bus, 8'ha1);
    tick(1, 1, 8'hff, 0, 0, rdy, wr, bus);
    chk(!rdy && wr && bus == 8'hb2, "R9 pair continues B", bus, 8'hb2);
    tick(1, 1, 8'hff, 0, 0, rdy, wr, bus);
    chk(!rdy && wr && bus == 8'ha1, "R9 pair continues A", bus, 8'ha1);
    tick(1, 1, 8'hff, 0, 0, rdy, wr, bus);
    chk(!rdy && wr && bus == 8'hb2, "R9 pair continues B2", bus, 8'hb2);
    tick(1, 1, 8'h77, 0, 0, rdy, wr, bus);
    chk(rdy && wr && bus == 8'h77, "R9 new mode at boundary", bus, 8'h77);
    chk(underflow == 1, "R8 underflow sticky", underflow, 1);
    do_reset();
    chk(underflow == 0, "R8 reset clears underflow", underflow, 1'b0);

    // R9/R7: doubled word, control change and freeze mid-repeat
    tick(1, 1, 8'h11, 1, 0, rdy, wr, bus);
    chk(rdy && wr && bus == 8'h11, "R2 first copy", bus, 8'h11);
    for (int i = 0; i < 3; i++) begin
      tick(0, 1, 8'h22, 0, 0, rdy, wr, bus);
      chk(!rdy && !wr, "R7 frozen mid-repeat", {rdy, wr}, 0);
    end
    tick(1, 1, 8'h22, 0, 0, rdy, wr, bus);
    chk(!rdy && wr && bus == 8'h11, "R9 repeat finishes after change", bus, 8'h11);
    tick(1, 1, 8'h22, 0, 0, rdy, wr, bus);
    chk(rdy && wr && bus == 8'h22, "R1 plain after boundary", bus, 8'h22);
    tick(1, 0, 8'h00, 0, 0, rdy, wr, bus);
    chk(!wr && bus == 8'h22 && underflow, "R8 gap holds bus", {wr, bus}, 8'h22);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule